// File: doc/BRIEF.md
# Prescaled Reload Timer With Compare

This block is a general-purpose up-counting timer core for the functional clock domain. Software programs it through a synchronous write port. The port holds a control word, a counter, a load value, a reload trigger, a match value and a sticky status word. The counter advances on every clock, or, with the prescaler on, once per 2^(v+1) clocks. At the all-ones value it wraps: in periodic mode it reloads from the load value, and in one-shot mode it falls to zero and stops. When comparison is on, reaching the match value raises an event. Overflow and match events drive an output pin. That pin either pulses for one prescaled tick or toggles. It can also be set to follow the control word's level bit as a plain general-purpose output.

A separate input pin is watched for a selected edge: rising, falling or both. On that edge the current counter value is latched into a capture register. In hold mode the first capture is kept until software clears the capture flag.

The write port has no back-pressure. A write is accepted in every cycle in which `wr_en` is high, and it takes effect at that clock edge. A write to the counter or to the trigger overrides a counter step in the same cycle, and the overriding write raises no event.

Top module: `gp_reload_timer`

## Requirements
- R1: After reset the counter, capture value and status are zero, the timer is stopped and `pwm_o` is 0.
- R2: Writing control bit 0 (start) to 1 makes the counter advance by one each clock when bit 5 (prescaler enable) is 0. The counter holds while start is 0.
- R3: With bit 5 set, the counter advances once every 2^(v+1) clocks, where v is control bits 4:2. The first advance comes 2^(v+1) clocks after start is written.
- R4: On a step from all-ones the overflow flag (status bit 0) sets. With control bit 1 (auto-reload) set, the counter takes the load value (address 2) and keeps running.
- R5: On a step from all-ones with auto-reload clear, the counter becomes 0, start clears (`running_o` falls) and counting stops.
- R6: Any write to address 3 (trigger) loads the counter from the load value. A write to address 1 sets the counter directly. Both take effect at the write's clock edge.
- R7: With control bit 6 (compare enable) set, a step that makes the counter equal the match value (address 4) sets the match flag (status bit 1). With bit 6 clear the match flag is never set.
- R8: In pulse mode (bit 12 = 0), an overflow or match event drives `pwm_o` to the inverse of bit 7 (default level) until the next prescaled tick. Otherwise `pwm_o` equals bit 7.
- R9: In toggle mode (bit 12 = 1), `pwm_o` equals bit 7 XOR a state that inverts on each event step.
- R10: With bit 14 set, `pwm_o` equals bit 7 regardless of events.
- R11: Control bits 9:8 select the capture edge on `cap_in`: 00 none, 01 rising, 10 falling, 11 both. A selected edge latches the counter value from before that edge into `cap_val_o` and sets the capture flag (status bit 2).
- R12: With bit 13 (capture hold) set, no new capture is taken while the capture flag is set.
- R13: Status flags are sticky. Writing 1 to a bit at address 5 clears that flag, and writing 0 leaves it. A flag set in the same cycle as its clear stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | 0 control, 1 counter, 2 load, 3 trigger, 4 match, 5 status clear |
| wr_data | input | WIDTH | Write data |
| cap_in | input | 1 | Capture input pin |
| count_o | output | WIDTH | Current counter value |
| cap_val_o | output | WIDTH | Last captured counter value |
| status_o | output | 3 | Sticky flags: bit 0 overflow, bit 1 match, bit 2 capture |
| running_o | output | 1 | Control start bit |
| pwm_o | output | 1 | Event/PWM/general-purpose output pin |

## Verification
The bench sweeps every prescaler setting and samples one clock before and exactly at the first advance. An off-by-one divider would show the counter one step early or late. It runs the all-ones wrap in both reload modes. A design that reloaded in one-shot mode, or failed to clear start, would show a non-zero counter or a still-high `running_o`. The capture check sweeps all four edge selections against both transitions and then exercises the hold mode. A design that took the counter value after the edge, or overwrote a held capture, reports a wrong `cap_val_o`. The output checks cover pulse width under the prescaler, toggle ordering between match and overflow, and the general-purpose override.

// File: rtl/gp_timer_pkg.sv
package gp_timer_pkg;
  localparam int PRE_W = 3;

  localparam logic [2:0] ADDR_CTRL  = 3'd0;
  localparam logic [2:0] ADDR_COUNT = 3'd1;
  localparam logic [2:0] ADDR_LOAD  = 3'd2;
  localparam logic [2:0] ADDR_TRIG  = 3'd3;
  localparam logic [2:0] ADDR_MATCH = 3'd4;
  localparam logic [2:0] ADDR_STAT  = 3'd5;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_e;

  typedef struct packed {
    logic             gpo;
    logic             cap_hold;
    logic             toggle;
    edge_e            edge_sel;
    logic             def_lvl;
    logic             cmp_en;
    logic             pre_en;
    logic [PRE_W-1:0] pre_val;
    logic             auto_rl;
    logic             start;
  } ctrl_t;

  function automatic ctrl_t decode_ctrl(input logic [14:0] w);
    ctrl_t c;
    c.start    = w[0];
    c.auto_rl  = w[1];
    c.pre_val  = w[4:2];
    c.pre_en   = w[5];
    c.cmp_en   = w[6];
    c.def_lvl  = w[7];
    c.edge_sel = edge_e'(w[9:8]);
    c.toggle   = w[12];
    c.cap_hold = w[13];
    c.gpo      = w[14];
    return c;
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             pre_en,
  input  logic [PRE_W-1:0] pre_val,
  output logic             tick
);
  localparam int PCW = 1 << PRE_W;

  logic [PCW-1:0] pc_q;
  logic [PCW-1:0] lim;

  for (genvar i = 0; i < PCW; i++) begin : g_lim
    assign lim[i] = (PRE_W'(i) <= pre_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     pc_q <= '0;
    else if (!run || !pre_en)       pc_q <= '0;
    else if (pc_q == lim)           pc_q <= '0;
    else                            pc_q <= pc_q + 1'b1;
  end

  assign tick = run && (!pre_en || (pc_q == lim));

  assert_tick_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pre_en) |=> (!tick || !pre_en));
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cmp_en,
  input  logic             auto_rl,
  input  logic [WIDTH-1:0] load_val,
  input  logic [WIDTH-1:0] match_val,
  input  logic             wr_cnt,
  input  logic             wr_trig,
  input  logic [WIDTH-1:0] wr_val,
  output logic [WIDTH-1:0] cnt,
  output logic             ovf_evt,
  output logic             match_evt
);
  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] nxt;
  logic             step_en;
  logic             at_max;

  always_comb begin
    at_max    = &cnt_q;
    step_en   = tick && !wr_cnt && !wr_trig;
    nxt       = at_max ? (auto_rl ? load_val : '0) : cnt_q + 1'b1;
    ovf_evt   = step_en && at_max;
    match_evt = step_en && cmp_en && (nxt == match_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (wr_cnt)  cnt_q <= wr_val;
    else if (wr_trig) cnt_q <= load_val;
    else if (step_en) cnt_q <= nxt;
  end

  assign cnt = cnt_q;

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_cnt && !wr_trig) |=> $stable(cnt));
  assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && auto_rl) |=> (cnt == $past(load_val)));
  assert_trigger_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_trig |=> (cnt == $past(load_val)));
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture #(
  parameter int WIDTH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_in,
  input  gp_timer_pkg::edge_e edge_sel,
  input  logic              hold,
  input  logic              flag_in,
  input  logic [WIDTH-1:0]  cnt,
  output logic              cap_evt,
  output logic [WIDTH-1:0]  cap_val
);
  import gp_timer_pkg::*;

  logic             prev_q;
  logic [WIDTH-1:0] val_q;
  logic             hit;

  always_comb begin
    unique case (edge_sel)
      EDGE_RISE: hit = cap_in && !prev_q;
      EDGE_FALL: hit = !cap_in && prev_q;
      EDGE_BOTH: hit = cap_in != prev_q;
      default:   hit = 1'b0;
    endcase
    cap_evt = hit && !(hold && flag_in);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      val_q  <= '0;
    end else begin
      prev_q <= cap_in;
      if (cap_evt) val_q <= cnt;
    end
  end

  assign cap_val = val_q;

  assert_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && flag_in) |=> $stable(cap_val));
endmodule

// File: rtl/tmr_outgen.sv
module tmr_outgen (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  input  logic evt,
  input  logic def_lvl,
  input  logic toggle,
  input  logic gpo,
  output logic out
);
  logic tog_q;
  logic pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      if (evt && toggle) tog_q <= !tog_q;
      if (!run)                 pulse_q <= 1'b0;
      else if (evt && !toggle)  pulse_q <= 1'b1;
      else if (tick)            pulse_q <= 1'b0;
    end
  end

  always_comb begin
    if (gpo)         out = def_lvl;
    else if (toggle) out = def_lvl ^ tog_q;
    else             out = def_lvl ^ pulse_q;
  end
endmodule

// File: rtl/gp_reload_timer.sv
module gp_reload_timer #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             cap_in,
  output logic [WIDTH-1:0] count_o,
  output logic [WIDTH-1:0] cap_val_o,
  output logic [2:0]       status_o,
  output logic             running_o,
  output logic             pwm_o
);
  import gp_timer_pkg::*;

  localparam int NFLAG = 3;

  ctrl_t            ctrl_q;
  logic [WIDTH-1:0] load_q;
  logic [WIDTH-1:0] match_q;
  logic [NFLAG-1:0] stat_q;
  logic [NFLAG-1:0] stat_set;
  logic             wr_ctrl, wr_cnt, wr_trig, wr_stat;
  logic             tick, ovf_evt, match_evt, cap_evt;
  logic [WIDTH-1:0] cnt;

  assign wr_ctrl = wr_en && (wr_addr == ADDR_CTRL);
  assign wr_cnt  = wr_en && (wr_addr == ADDR_COUNT);
  assign wr_trig = wr_en && (wr_addr == ADDR_TRIG);
  assign wr_stat = wr_en && (wr_addr == ADDR_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      load_q  <= '0;
      match_q <= '0;
    end else begin
      if (wr_ctrl)                           ctrl_q <= decode_ctrl(wr_data[14:0]);
      else if (ovf_evt && !ctrl_q.auto_rl)   ctrl_q.start <= 1'b0;
      if (wr_en && wr_addr == ADDR_LOAD)     load_q  <= wr_data;
      if (wr_en && wr_addr == ADDR_MATCH)    match_q <= wr_data;
    end
  end

  tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q.start), .pre_en(ctrl_q.pre_en),
    .pre_val(ctrl_q.pre_val), .tick(tick)
  );

  tmr_core #(.WIDTH(WIDTH)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmp_en(ctrl_q.cmp_en),
    .auto_rl(ctrl_q.auto_rl), .load_val(load_q), .match_val(match_q),
    .wr_cnt(wr_cnt), .wr_trig(wr_trig), .wr_val(wr_data),
    .cnt(cnt), .ovf_evt(ovf_evt), .match_evt(match_evt)
  );

  tmr_capture #(.WIDTH(WIDTH)) u_cap (
    .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .edge_sel(ctrl_q.edge_sel),
    .hold(ctrl_q.cap_hold), .flag_in(stat_q[2]), .cnt(cnt),
    .cap_evt(cap_evt), .cap_val(cap_val_o)
  );

  tmr_outgen u_out (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q.start), .tick(tick),
    .evt(ovf_evt || match_evt), .def_lvl(ctrl_q.def_lvl),
    .toggle(ctrl_q.toggle), .gpo(ctrl_q.gpo), .out(pwm_o)
  );

  assign stat_set = {cap_evt, match_evt, ovf_evt};

  for (genvar f = 0; f < NFLAG; f++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           stat_q[f] <= 1'b0;
      else if (stat_set[f]) stat_q[f] <= 1'b1;
      else if (wr_stat && wr_data[f]) stat_q[f] <= 1'b0;
    end

    assert_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[f] && !(wr_stat && wr_data[f])) |=> stat_q[f]);
  end

  assign count_o   = cnt;
  assign status_o  = stat_q;
  assign running_o = ctrl_q.start;

  assert_oneshot_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && !ctrl_q.auto_rl && !wr_ctrl) |=> !running_o);
  assert_gpo_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.gpo |-> (pwm_o == ctrl_q.def_lvl));
  assert_no_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.cmp_en |-> !match_evt);
endmodule

// File: tb/gp_reload_timer_tb.sv
module gp_reload_timer_tb;
  localparam int W = 32;
  localparam logic [W-1:0] C_START = 32'h1, C_AR = 32'h2, C_PRE = 32'h20,
    C_CE = 32'h40, C_DEF = 32'h80, C_TOG = 32'h1000, C_HOLD = 32'h2000,
    C_GPO = 32'h4000;

  logic clk = 0, rst_n = 0, wr_en = 0, cap_in = 0;
  logic [2:0] wr_addr = 0;
  logic [W-1:0] wr_data = 0;
  logic [W-1:0] count_o, cap_val_o;
  logic [2:0] status_o;
  logic running_o, pwm_o;
  int checks = 0, errors = 0;
  bit done = 0;

  gp_reload_timer #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cap_in(cap_in), .count_o(count_o),
    .cap_val_o(cap_val_o), .status_o(status_o), .running_o(running_o),
    .pwm_o(pwm_o)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3); rst_n = 1; step(1);
    // R1 reset state
    chk("R1 count", count_o, 0); chk("R1 status", 32'(status_o), 0);
    chk("R1 run", 32'(running_o), 0); chk("R1 pwm", 32'(pwm_o), 0);
    chk("R1 cap", cap_val_o, 0);
    step(3); chk("R1 idle hold", count_o, 0);

    // R2 plain counting
    wr(1, 100); wr(0, C_START);
    chk("R2 start", count_o, 100);
    step(7); chk("R2 count", count_o, 107);
    wr(0, 0); step(4); chk("R2 stopped", count_o, 108);

    // R3 prescaler sweep over all values
    for (int v = 0; v < 8; v++) begin
      int d;
      d = 1 << (v + 1);
      wr(0, 0); wr(1, 0); wr(0, C_START | C_PRE | (v << 2));
      step(d - 1); chk($sformatf("R3 v%0d before", v), count_o, 0);
      step(1);     chk($sformatf("R3 v%0d first", v), count_o, 1);
      step(2 * d); chk($sformatf("R3 v%0d third", v), count_o, 3);
    end

    // R4 overflow with auto-reload
    wr(0, 0); wr(2, 32'h10); wr(1, 32'hFFFF_FFFD); wr(0, C_START | C_AR);
    step(2); chk("R4 at max", count_o, 32'hFFFF_FFFF);
    chk("R4 no flag yet", 32'(status_o[0]), 0);
    step(1); chk("R4 reload", count_o, 32'h10);
    chk("R4 flag", 32'(status_o[0]), 1); chk("R4 running", 32'(running_o), 1);
    step(2); chk("R4 continues", count_o, 32'h12);

    // R13 write-1-to-clear
    wr(5, 0); chk("R13 zero write keeps", 32'(status_o[0]), 1);
    wr(5, 1); chk("R13 clear", 32'(status_o[0]), 0);

    // R5 one-shot
    wr(0, 0); wr(1, 32'hFFFF_FFFE); wr(0, C_START);
    step(1); chk("R5 at max", count_o, 32'hFFFF_FFFF);
    step(1); chk("R5 wrap zero", count_o, 0);
    chk("R5 stopped", 32'(running_o), 0); chk("R5 flag", 32'(status_o[0]), 1);
    step(5); chk("R5 stays", count_o, 0);
    wr(5, 1);

    // R6 trigger and direct write while running
    wr(2, 32'h55); wr(1, 32'h200); wr(0, C_START);
    step(4); wr(3, 0); chk("R6 trigger", count_o, 32'h55);
    step(3); chk("R6 after trigger", count_o, 32'h58);
    wr(1, 32'h900); chk("R6 direct", count_o, 32'h900);
    step(2); chk("R6 after direct", count_o, 32'h902);

    // R7 compare off then on
    wr(0, 0); wr(4, 3); wr(1, 0); wr(0, C_START);
    step(5); chk("R7 off no flag", 32'(status_o[1]), 0);
    wr(0, 0); wr(1, 0); wr(0, C_START | C_CE);
    step(2); chk("R7 before", 32'(status_o[1]), 0);
    step(1); chk("R7 hit", 32'(status_o[1]), 1); chk("R7 count", count_o, 3);
    wr(5, 2); chk("R13 match clear", 32'(status_o[1]), 0);

    // R8 pulse mode, default low, no prescaler
    wr(0, 0); wr(4, 5); wr(1, 0); wr(0, C_START | C_CE);
    step(4); chk("R8 idle", 32'(pwm_o), 0);
    step(1); chk("R8 pulse", 32'(pwm_o), 1);
    step(1); chk("R8 end", 32'(pwm_o), 0);
    // R8 default high with prescaler v=0 (tick every 2)
    wr(0, C_DEF); chk("R8 def high idle", 32'(pwm_o), 1);
    wr(1, 0); wr(0, C_START | C_CE | C_DEF | C_PRE);
    step(9);  chk("R8 pre before", 32'(pwm_o), 1);
    step(1);  chk("R8 pre pulse", 32'(pwm_o), 0);
    step(1);  chk("R8 pre hold", 32'(pwm_o), 0);
    step(1);  chk("R8 pre end", 32'(pwm_o), 1);

    // R9 toggle on match then overflow
    wr(0, 0); wr(2, 32'hFFFF_FFF0); wr(4, 32'hFFFF_FFF8); wr(1, 32'hFFFF_FFF0);
    wr(0, C_START | C_AR | C_CE | C_TOG);
    step(7); chk("R9 t7", 32'(pwm_o), 0);
    step(1); chk("R9 match", 32'(pwm_o), 1);
    step(7); chk("R9 t15", 32'(pwm_o), 1);
    step(1); chk("R9 overflow", 32'(pwm_o), 0); chk("R9 count", count_o, 32'hFFFF_FFF0);
    step(8); chk("R9 second match", 32'(pwm_o), 1);
    wr(5, 7);

    // R10 general-purpose output override
    wr(0, 0); wr(4, 2); wr(1, 0); wr(0, C_START | C_CE | C_GPO | C_DEF);
    step(2); chk("R10 level", 32'(pwm_o), 1); chk("R10 event seen", 32'(status_o[1]), 1);
    step(1); chk("R10 level after", 32'(pwm_o), 1);
    wr(0, C_GPO); chk("R10 low", 32'(pwm_o), 0);
    wr(5, 7);

    // R11 capture edge sweep
    begin
      logic [W-1:0] exp_v;
      exp_v = 0;
      for (int m = 0; m < 4; m++) begin
        wr(0, 0); wr(5, 4); wr(1, 1000); wr(0, C_START | (m << 8));
        step(3); cap_in = 1; step(1);
        if (m[0]) exp_v = 1003;
        chk($sformatf("R11 m%0d rise flag", m), 32'(status_o[2]), 32'(m[0]));
        chk($sformatf("R11 m%0d rise val", m), cap_val_o, exp_v);
        step(4); cap_in = 0; step(1);
        if (m[1]) exp_v = 1008;
        chk($sformatf("R11 m%0d fall flag", m), 32'(status_o[2]), 32'(m != 0));
        chk($sformatf("R11 m%0d fall val", m), cap_val_o, exp_v);
      end
    end

    // R12 capture hold
    wr(0, 0); wr(5, 4); wr(1, 2000); wr(0, C_START | C_HOLD | (1 << 8));
    step(2); cap_in = 1; step(1);
    chk("R12 first", cap_val_o, 2002);
    cap_in = 0; step(1); cap_in = 1; step(1);
    chk("R12 held", cap_val_o, 2002);
    wr(5, 4); cap_in = 0; step(1); cap_in = 1; step(1);
    chk("R12 after clear", cap_val_o, 2007);
    chk("R12 flag", 32'(status_o[2]), 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule